// File: doc/BRIEF.md
# PHY Basic Control Register

This block holds the 16-bit basic control word of a 10 Mbit/s half-duplex Ethernet PHY. It also contains the small datapath that the word steers. A management agent writes and reads the word over a simple single-cycle register bus at one address. Four fields can be written: loopback, power down, isolate and collision test. The speed, duplex and auto-negotiation positions are fixed at zero. Writing the top bit starts a one-cycle soft reset. The soft reset returns every field to zero except those marked sticky by a parameter.

The datapath sits between the MAC-facing MII signals and the line-side transmit and receive signals. In loopback, MAC transmit data and enable come back on the MAC receive outputs, and the line transmit side is held quiet. Isolation drives the MAC-facing outputs to zero and drops their output enable. With collision test and loopback both set, a timer clocked by a one-bit-time strobe raises COL a fixed number of bit times after TXEN rises. It drops COL a smaller fixed number of bit times after TXEN falls. Power down only drives the PMA power-down output.

Top module: `phy_basic_ctl`

## Requirements
- R1: After reset, every field reads 0, `pma_pd` and `phy_srst` are 0, and the datapath is in normal pass-through with `mac_rx_oe` at 1.
- R2: A write to `REG_ADDR` stores bit 14 (loopback), bit 11 (power down), bit 10 (isolate) and bit 7 (collision test). A read at `REG_ADDR` returns them in those positions. A read at any other address, or with `reg_rd` low, returns 0.
- R3: Read data bits 15, 13, 12, 9, 8, 6 and 5..0 are always 0, whatever was written.
- R4: A write with bit 15 set ignores the other data bits. At the same clock edge it clears every field not in `STICKY_MASK` and keeps every sticky field. `phy_srst` is then high for exactly one cycle, and reads during that cycle show the post-reset value.
- R5: A write that arrives during the cycle in which `phy_srst` is high is ignored.
- R6: With loopback set, `mac_rxd`/`mac_rxdv` equal `mac_txd`/`mac_txen`, and `line_txd`/`line_txen` are 0.
- R7: With loopback clear, `line_txd`/`line_txen` equal `mac_txd`/`mac_txen`, and `mac_rxd`/`mac_rxdv` equal `line_rxd`/`line_rxdv`.
- R8: `pma_pd` equals the power-down field, and the datapath keeps working while it is set.
- R9: With isolate set, `mac_rxd`, `mac_rxdv` and `mac_col` are 0 and `mac_rx_oe` is 0.
- R10: With collision test and loopback both set, COL rises on the clock edge that registers the `COL_RISE_BT`-th strobe seen while `mac_txen` is held high. It falls on the edge of the `COL_FALL_BT`-th strobe seen while `mac_txen` is held low.
- R11: COL stays 0 whenever collision test or loopback is clear, including collision test without loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| bit_stb | input | 1 | One-cycle pulse per bit time |
| mac_txd | input | DATA_W | Transmit data from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| mac_rxd | output | DATA_W | Receive data to the MAC |
| mac_rxdv | output | 1 | Receive valid to the MAC |
| mac_col | output | 1 | Collision indication to the MAC |
| mac_rx_oe | output | 1 | Output enable of the MAC-facing outputs |
| line_txd | output | DATA_W | Transmit data toward the line side |
| line_txen | output | 1 | Transmit enable toward the line side |
| line_rxd | input | DATA_W | Receive data from the line side |
| line_rxdv | input | 1 | Receive valid from the line side |
| pma_pd | output | 1 | PMA power-down request |
| phy_srst | output | 1 | One-cycle soft-reset pulse to the rest of the PHY |

## Verification
The bench builds the block with `DATA_W` = 4, `ADDR_W` = 5, `REG_ADDR` = 0, `COL_RISE_BT` = 64, `COL_FALL_BT` = 2 and `STICKY_MASK` = 16'h0800. With power down marked sticky, one soft reset can show both behaviours: a field that is cleared and a field that is kept. The strobe pulses every fourth clock, so the 64-bit-time rise window spans about 256 cycles. Directed probes just before and just after that window fix the rise point, and the same holds for the 2-bit-time fall. A 4-bit data width with varying transmit and receive patterns shows which source each steering mode selects.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
   localparam int unsigned CTL_W = 16;

   localparam int unsigned F_SRST = 15;
   localparam int unsigned F_LB   = 14;
   localparam int unsigned F_PD   = 11;
   localparam int unsigned F_ISO  = 10;
   localparam int unsigned F_CT   = 7;

   // positions that hold state across cycles (soft reset bit excluded)
   localparam logic [CTL_W-1:0] KEEP_MASK =
      (16'(1) << F_LB) | (16'(1) << F_PD) | (16'(1) << F_ISO) | (16'(1) << F_CT);

   typedef struct packed {
      logic lb;
      logic pd;
      logic iso;
      logic ct;
   } ctl_fields_t;
endpackage

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
   import phy_ctl_pkg::*;
#(
   parameter int unsigned      ADDR_W      = 5,
   parameter int unsigned      REG_ADDR    = 0,
   parameter logic [CTL_W-1:0] STICKY_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CTL_W-1:0]  wdata,
   output logic [CTL_W-1:0]  rdata,
   output ctl_fields_t       fields,
   output logic              srst
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   if (REG_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("REG_ADDR does not fit in ADDR_W bits");
   end
   if ((STICKY_MASK & ~KEEP_MASK) != '0) begin : g_bad_sticky
      $error("STICKY_MASK names a position that holds no state");
   end

   logic             wr_hit;
   logic             srst_req;
   logic [CTL_W-1:0] ctl_q;
   logic             unused_wdata;

   assign wr_hit       = wr && (addr == HIT_ADDR) && !srst;
   assign srst_req     = wr_hit && wdata[F_SRST];
   assign unused_wdata = ^(wdata & ~(KEEP_MASK | (16'(1) << F_SRST)));

   for (genvar i = 0; i < CTL_W; i++) begin : g_bit
      if (!KEEP_MASK[i]) begin : g_fixed
         assign ctl_q[i] = 1'b0;
      end else if (STICKY_MASK[i]) begin : g_sticky
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       q <= 1'b0;
            else if (wr_hit && !wdata[F_SRST]) q <= wdata[i];
         end
         assign ctl_q[i] = q;
      end else begin : g_plain
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (srst_req) q <= 1'b0;
            else if (wr_hit)   q <= wdata[i];
         end
         assign ctl_q[i] = q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) srst <= 1'b0;
      else        srst <= srst_req;
   end

   assign rdata      = (rd && addr == HIT_ADDR) ? ctl_q : '0;
   assign fields.lb  = ctl_q[F_LB];
   assign fields.pd  = ctl_q[F_PD];
   assign fields.iso = ctl_q[F_ISO];
   assign fields.ct  = ctl_q[F_CT];

   // R3: fixed positions never show a one
   a_r3_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~KEEP_MASK) == '0);
   // R4: the soft reset pulse lasts a single cycle
   a_r4_srst_single: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !srst);
   // R4: entering soft reset leaves only sticky fields possibly set
   a_r4_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srst) |-> (ctl_q & ~STICKY_MASK) == '0);
   // R5: fields do not move while the pulse is out
   a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> $stable(ctl_q));
endmodule

// File: rtl/phy_ctl_coltest.sv
module phy_ctl_coltest #(
   parameter int unsigned RISE_BT = 64,
   parameter int unsigned FALL_BT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic txen,
   input  logic bit_stb,
   output logic col
);
   localparam int unsigned MAX_BT = (RISE_BT > FALL_BT) ? RISE_BT : FALL_BT;
   localparam int unsigned CNT_W  = $clog2(MAX_BT + 1);
   localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(RISE_BT - 1);
   localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(FALL_BT - 1);

   if (RISE_BT < 1 || RISE_BT > 512) begin : g_bad_rise
      $error("RISE_BT must lie in 1..512 bit times");
   end
   if (FALL_BT < 1 || FALL_BT > 4) begin : g_bad_fall
      $error("FALL_BT must lie in 1..4 bit times");
   end

   logic [CNT_W-1:0] cnt;
   logic             wait_edge;  // txen level that keeps the timer idle

   assign wait_edge = col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= 1'b0;
         cnt <= '0;
      end else if (!active) begin
         col <= 1'b0;
         cnt <= '0;
      end else if (txen == wait_edge) begin
         cnt <= '0;
      end else if (bit_stb) begin
         if (cnt == (col ? FALL_LAST : RISE_LAST)) begin
            col <= !col;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R11: no collision report outside the test mode
   a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !col);
   // R10: a rise only follows a cycle with txen high
   a_r10_rise_on_txen: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col) |-> $past(txen) && $past(active));
   // R10: a fall follows txen low or leaving the test mode
   a_r10_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col) |-> !$past(txen) || !$past(active));
endmodule

// File: rtl/phy_ctl_mii.sv
module phy_ctl_mii #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              lb,
   input  logic              iso,
   input  logic              col_in,
   input  logic [DATA_W-1:0] mac_txd,
   input  logic              mac_txen,
   output logic [DATA_W-1:0] mac_rxd,
   output logic              mac_rxdv,
   output logic              mac_col,
   output logic              mac_rx_oe,
   output logic [DATA_W-1:0] line_txd,
   output logic              line_txen,
   input  logic [DATA_W-1:0] line_rxd,
   input  logic              line_rxdv
);
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] rx_sel_d;
   logic              rx_sel_v;

   always_comb begin
      if (lb) begin
         rx_sel_d  = mac_txd;
         rx_sel_v  = mac_txen;
         line_txd  = '0;
         line_txen = 1'b0;
      end else begin
         rx_sel_d  = line_rxd;
         rx_sel_v  = line_rxdv;
         line_txd  = mac_txd;
         line_txen = mac_txen;
      end
   end

   always_comb begin
      mac_rx_oe = !iso;
      mac_rxd   = iso ? '0 : rx_sel_d;
      mac_rxdv  = iso ? 1'b0 : rx_sel_v;
      mac_col   = iso ? 1'b0 : col_in;
   end

   // R9: a disabled output never carries valid or collision
   a_r9_quiet_when_off: assert final (mac_rx_oe || (!mac_rxdv && !mac_col && mac_rxd == '0));
   // R6: the line side never sees transmit while the MAC sees its own frame
   a_r6_line_quiet: assert final (!(line_txen && lb));
endmodule

// File: rtl/phy_basic_ctl.sv
module phy_basic_ctl
   import phy_ctl_pkg::*;
#(
   parameter int unsigned      DATA_W      = 4,
   parameter int unsigned      ADDR_W      = 5,
   parameter int unsigned      REG_ADDR    = 0,
   parameter int unsigned      COL_RISE_BT = 64,
   parameter int unsigned      COL_FALL_BT = 2,
   parameter logic [CTL_W-1:0] STICKY_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              bit_stb,
   input  logic [DATA_W-1:0] mac_txd,
   input  logic              mac_txen,
   output logic [DATA_W-1:0] mac_rxd,
   output logic              mac_rxdv,
   output logic              mac_col,
   output logic              mac_rx_oe,
   output logic [DATA_W-1:0] line_txd,
   output logic              line_txen,
   input  logic [DATA_W-1:0] line_rxd,
   input  logic              line_rxdv,
   output logic              pma_pd,
   output logic              phy_srst
);
   ctl_fields_t fields;
   logic        col_raw;

   phy_ctl_regs #(
      .ADDR_W      (ADDR_W),
      .REG_ADDR    (REG_ADDR),
      .STICKY_MASK (STICKY_MASK)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .rd     (reg_rd),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .fields (fields),
      .srst   (phy_srst)
   );

   phy_ctl_coltest #(
      .RISE_BT (COL_RISE_BT),
      .FALL_BT (COL_FALL_BT)
   ) i_coltest (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (fields.ct && fields.lb),
      .txen    (mac_txen),
      .bit_stb (bit_stb),
      .col     (col_raw)
   );

   phy_ctl_mii #(
      .DATA_W (DATA_W)
   ) i_mii (
      .lb        (fields.lb),
      .iso       (fields.iso),
      .col_in    (col_raw),
      .mac_txd   (mac_txd),
      .mac_txen  (mac_txen),
      .mac_rxd   (mac_rxd),
      .mac_rxdv  (mac_rxdv),
      .mac_col   (mac_col),
      .mac_rx_oe (mac_rx_oe),
      .line_txd  (line_txd),
      .line_txen (line_txen),
      .line_rxd  (line_rxd),
      .line_rxdv (line_rxdv)
   );

   assign pma_pd = fields.pd;

   // R8: power down request tracks what a read shows
   a_r8_pd_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(REG_ADDR)) |-> reg_rdata[F_PD] == pma_pd);
endmodule

// File: tb/test_phy_basic_ctl.sv
module test_phy_basic_ctl;
   localparam int CLK_P  = 10;
   localparam int DW     = 4;
   localparam int AW     = 5;
   localparam int RISE   = 64;
   localparam int FALL   = 2;
   localparam logic [15:0] STICKY = 16'h0800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          bit_stb = 1'b0;
   logic [DW-1:0] mac_txd = '0;
   logic          mac_txen = 1'b0;
   logic [DW-1:0] mac_rxd;
   logic          mac_rxdv, mac_col, mac_rx_oe;
   logic [DW-1:0] line_txd;
   logic          line_txen;
   logic [DW-1:0] line_rxd = '0;
   logic          line_rxdv = 1'b0;
   logic          pma_pd, phy_srst;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_P/2) clk = !clk;

   phy_basic_ctl #(
      .DATA_W(DW), .ADDR_W(AW), .REG_ADDR(0),
      .COL_RISE_BT(RISE), .COL_FALL_BT(FALL), .STICKY_MASK(STICKY)
   ) i_phy_basic_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bit_stb(bit_stb), .mac_txd(mac_txd), .mac_txen(mac_txen),
      .mac_rxd(mac_rxd), .mac_rxdv(mac_rxdv), .mac_col(mac_col),
      .mac_rx_oe(mac_rx_oe), .line_txd(line_txd), .line_txen(line_txen),
      .line_rxd(line_rxd), .line_rxdv(line_rxdv), .pma_pd(pma_pd),
      .phy_srst(phy_srst)
   );

   // ---------------- behavioural reference ----------------
   bit m_lb, m_pd, m_iso, m_ct, m_srst, m_col;
   int m_strobes;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_lb, m_pd, m_iso, m_ct, m_srst, m_col} = '0;
         m_strobes = 0;
      end else begin
         // collision timer uses the mode that held during this cycle
         if (!(m_ct && m_lb)) begin
            m_col = 0; m_strobes = 0;
         end else if (mac_txen == m_col) begin
            m_strobes = 0;
         end else if (bit_stb) begin
            m_strobes++;
            if (m_strobes == (m_col ? FALL : RISE)) begin
               m_col = !m_col; m_strobes = 0;
            end
         end
         if (m_srst) begin
            m_srst = 0;                         // R5: write dropped
         end else if (reg_wr && reg_addr == 0) begin
            if (reg_wdata[15]) begin
               m_srst = 1;
               m_lb = 0; m_iso = 0; m_ct = 0;   // pd is sticky here
            end else begin
               m_lb = reg_wdata[14]; m_pd = reg_wdata[11];
               m_iso = reg_wdata[10]; m_ct = reg_wdata[7];
            end
         end
      end
   end

   task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [15:0]   e_rd;
         logic [DW-1:0] e_rxd;
         logic          e_dv;
         e_rd = (reg_rd && reg_addr == 0) ?
                {1'b0, m_lb, 2'b00, m_pd, m_iso, 2'b00, m_ct, 7'b0} : 16'h0;
         cmp("R2 R3 R4 read data", 32'(reg_rdata), 32'(e_rd));
         cmp("R4 soft reset pulse", 32'(phy_srst), 32'(m_srst));
         cmp("R8 power down", 32'(pma_pd), 32'(m_pd));
         cmp("R6 R7 line txd", 32'(line_txd), m_lb ? 32'h0 : 32'(mac_txd));
         cmp("R6 R7 line txen", 32'(line_txen), m_lb ? 32'h0 : 32'(mac_txen));
         e_rxd = m_iso ? '0 : (m_lb ? mac_txd : line_rxd);
         e_dv  = m_iso ? 1'b0 : (m_lb ? mac_txen : line_rxdv);
         cmp("R6 R7 R9 mac rxd", 32'(mac_rxd), 32'(e_rxd));
         cmp("R6 R7 R9 mac rxdv", 32'(mac_rxdv), 32'(e_dv));
         cmp("R9 output enable", 32'(mac_rx_oe), 32'(!m_iso));
         cmp("R10 R11 col", 32'(mac_col), m_iso ? 32'h0 : 32'(m_col));
      end
   end

   // bit-time strobe: one cycle in four
   int stb_div = 0;
   always @(posedge clk) begin
      #2;
      stb_div = (stb_div + 1) % 4;
      bit_stb = (stb_div == 0);
   end

   task automatic tick(int n);
      repeat (n) begin
         @(posedge clk); #2;
         mac_txd = DW'($urandom); line_rxd = DW'($urandom);
         line_rxdv = 1'($urandom);
      end
   endtask

   task automatic wr_reg(logic [AW-1:0] a, logic [15:0] d);
      @(posedge clk); #2;
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_wr = 0;
   endtask

   task automatic probe(string tag, logic [31:0] act, logic [31:0] exp);
      @(negedge clk); #1;
      cmp(tag, act, exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      reg_rd = 1;
      @(negedge clk); #1;
      cmp("R1 reset read", 32'(reg_rdata), 32'h0);
      cmp("R1 reset pd", 32'(pma_pd), 32'h0);
      cmp("R1 reset oe", 32'(mac_rx_oe), 32'h1);

      tick(12);                                  // R7 pass-through
      mac_txen = 1; tick(6); mac_txen = 0;

      wr_reg(0, 16'h7FFF);                       // R3 fixed bits stay 0
      @(negedge clk); #1;
      cmp("R3 all-ones write", 32'(reg_rdata), 32'h4C80);
      reg_addr = 5'd3;
      @(negedge clk); #1;
      cmp("R2 other address", 32'(reg_rdata), 32'h0);
      reg_addr = 0;

      wr_reg(0, 16'h4000);                       // R6 loopback
      mac_txen = 1; tick(8); mac_txen = 0; tick(4);
      wr_reg(0, 16'h0400);                       // R9 isolate
      mac_txen = 1; tick(6); mac_txen = 0;
      wr_reg(0, 16'h4400); tick(4);
      wr_reg(0, 16'h0800);                       // R8 power down, datapath live
      mac_txen = 1; tick(6); mac_txen = 0;

      // R4 soft reset with other bits set, then R5 write in the pulse cycle
      wr_reg(0, 16'h4C80);
      @(posedge clk); #2;
      reg_wr = 1; reg_wdata = 16'hFFFF;
      @(posedge clk); #2;
      reg_wdata = 16'h4400;
      @(negedge clk); #1;
      cmp("R4 pulse high", 32'(phy_srst), 32'h1);
      cmp("R4 sticky kept", 32'(reg_rdata), 32'h0800);
      @(posedge clk); #2;
      reg_wr = 0;
      @(negedge clk); #1;
      cmp("R5 write in pulse ignored", 32'(reg_rdata), 32'h0800);
      cmp("R4 pulse ends", 32'(phy_srst), 32'h0);

      // R11 collision test without loopback
      wr_reg(0, 16'h0080);
      mac_txen = 1; tick(RISE * 4 + 20);
      probe("R11 no loopback", 32'(mac_col), 32'h0);
      mac_txen = 0; tick(4);

      // R10 timing
      wr_reg(0, 16'h4080);
      mac_txen = 1;
      tick(60 * 4);
      probe("R10 not yet high", 32'(mac_col), 32'h0);
      tick(8 * 4);
      probe("R10 high after window", 32'(mac_col), 32'h1);
      mac_txen = 0;
      tick(1);
      probe("R10 fall not instant", 32'(mac_col), 32'h1);
      tick(12);
      probe("R10 low after fall window", 32'(mac_col), 32'h0);
      mac_txen = 1; tick(RISE * 4 + 8);
      wr_reg(0, 16'h0080);                       // R11 leaving loopback drops col
      tick(2);
      probe("R11 drop on exit", 32'(mac_col), 32'h0);
      mac_txen = 0; tick(4);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule